// File: doc/BRIEF.md
# Ten-Bit-Address I2C Read Slave

This block is an I2C slave that answers to a programmable 10-bit address and sends data bytes back to the bus master. Both bus lines are brought through a synchroniser. The block pulls a line low only through its open-drain enable outputs, `scl_oe` and `sda_oe`. It detects START, repeated START and STOP conditions.

Addressing takes three phases. First the master sends a header byte `11110,A9,A8` with the direction bit at 0. Then it sends the low address byte. Then it issues a repeated START and sends the same header with the direction bit at 1. The slave acknowledges each byte that matches.

After each of the first two acknowledged bytes, the block raises an update-address flag. It holds SCL low until the host rewrites the 8-bit address register. The host keeps the header form (`1111_0A9A8_0`) in that register while a header is expected, and the low address byte while the low byte is expected.

After the read header, the block clears its clock-release bit and stretches SCL until the host loads a transmit byte and sets the bit again. The same hold is applied before every further byte that the master acknowledges.

Top module: `i2c10_slave`

## Requirements
- R1: After reset, both open-drain enables are 0. Buffer-full, update-address and interrupt flags are 0, and the clock-release bit is 1.
- R2: Outside an addressed session, a header byte whose bits [7:1] equal `addr_q[7:1]` and whose bit 0 is 0 is acknowledged. Any other byte is not acknowledged, and the slave then ignores further bytes until the next START or STOP.
- R3: The byte that follows an acknowledged write header is acknowledged only when it equals `addr_q`. Otherwise it gets a NACK.
- R4: At the end of the ninth clock of each of the first two acknowledged address bytes, `upd_addr` is set and SCL is held low. A host write to the address register clears `upd_addr` and releases SCL.
- R5: `irq` is set at the end of the ninth clock of every acknowledged byte, whether received or transmitted. It stays set until `irq_clr` is pulsed.
- R6: Every acknowledged address byte is copied to `rx_data` and sets `buf_full`. A `rx_re` pulse clears `buf_full`.
- R7: After a repeated START in an addressed session, a header with bit 0 equal to 1 is acknowledged. `clk_rel` is then cleared, and SCL is held low until `rel_set` is pulsed.
- R8: A `tx_we` write while the transmitter is held loads the byte and sets `buf_full`. The byte is sent MSB first, and `buf_full` clears once the eighth bit has been shifted out.
- R9: When the master acknowledges a transmitted byte, `clk_rel` is cleared and SCL is held again. When the master does not acknowledge it, the slave releases both lines and goes idle.
- R10: A STOP sends the slave to idle with both lines released and clears address progress. A read header sent after a STOP without the write phases is not acknowledged.
- R11: A read header (bit 0 equal to 1) sent before the write phases has completed gets a NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| addr_we | input | 1 | Host write strobe for the address register |
| addr_wdata | input | 8 | Address register write data |
| tx_we | input | 1 | Host write strobe for the transmit byte |
| tx_wdata | input | 8 | Transmit byte |
| rx_re | input | 1 | Host read strobe of the receive buffer |
| rel_set | input | 1 | Host sets the clock-release bit |
| irq_clr | input | 1 | Host clears the interrupt flag |
| addr_q | output | 8 | Address register contents |
| rx_data | output | 8 | Last received address byte |
| buf_full | output | 1 | Buffer-full flag |
| upd_addr | output | 1 | Address register needs updating |
| irq | output | 1 | Interrupt flag |
| clk_rel | output | 1 | Clock-release bit (0 stretches SCL in transmit) |

## Verification
The assertions check several rules on every cycle: the update-address flag always comes up together with an SCL hold, a host write clears it, the interrupt flag stays set until it is cleared, a release write takes effect, and after a STOP the slave sits idle with both lines released. Only the bench's master scenarios can show the rest. That covers the acknowledge decisions for matching and non-matching headers and low bytes, the ignoring of bytes after a mismatch, and the three-phase read handshake. It also covers the MSB-first bit order of returned data, the point where buffer-full clears, and the different endings after a master ACK or NACK.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACK, ST_WAIT, ST_TX, ST_TXACK
    } st_e;

    // which address byte the receiver expects next
    typedef enum logic [1:0] { K_HI, K_LO, K_RHI } kind_e;

    // where the ACK slot leads
    typedef enum logic [1:0] { N_LO, N_WAIT, N_TX } nxt_e;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic hdr_hit(logic [BYTE_W-1:0] b, logic [BYTE_W-1:0] a);
        return b[BYTE_W-1:1] == a[BYTE_W-1:1];
    endfunction
endpackage

// File: rtl/i2c10_linesync.sv
module i2c10_linesync
    import i2c10_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_sh, sda_sh;
    logic              scl_d, sda_d;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_d  <= scl_sh[STAGES-1];
            sda_d  <= sda_sh[STAGES-1];
        end
    end

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_comb begin
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_d;
        ev.scl_fall = ~scl_s & scl_d;
        ev.start    = scl_s & scl_d & sda_d & ~sda_s;
        ev.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2c10_engine.sv
module i2c10_engine
    import i2c10_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              addr_we,
    input  logic [BYTE_W-1:0] addr_wdata,
    input  logic              tx_we,
    input  logic [BYTE_W-1:0] tx_wdata,
    input  logic              rx_re,
    input  logic              rel_set,
    input  logic              irq_clr,
    output logic              sda_oe,
    output logic              scl_oe,
    output logic [BYTE_W-1:0] addr_q,
    output logic [BYTE_W-1:0] rx_data,
    output logic              buf_full,
    output logic              upd_addr,
    output logic              irq,
    output logic              clk_rel,
    output st_e               st_o
);
    st_e               st;
    kind_e             kind;
    nxt_e              nxt, nxt_c;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] sh;
    logic              addressed, m_ack, hit;

    always_comb begin
        hit   = 1'b0;
        nxt_c = N_LO;
        unique case (kind)
            K_HI:  begin hit = hdr_hit(sh, addr_q) & ~sh[0]; nxt_c = N_LO; end
            K_LO:  begin hit = (sh == addr_q);               nxt_c = N_WAIT; end
            K_RHI: begin hit = hdr_hit(sh, addr_q);          nxt_c = sh[0] ? N_TX : N_LO; end
            default: begin hit = 1'b0; nxt_c = N_LO; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; kind <= K_HI; nxt <= N_LO; bitcnt <= '0; sh <= '0;
            addressed <= 1'b0; m_ack <= 1'b0; addr_q <= '0; rx_data <= '0;
            buf_full <= 1'b0; upd_addr <= 1'b0; irq <= 1'b0; clk_rel <= 1'b1;
        end else begin
            if (ev.stop) begin
                st <= ST_IDLE; addressed <= 1'b0; kind <= K_HI; upd_addr <= 1'b0;
            end else if (ev.start) begin
                st     <= ST_RX;
                bitcnt <= '0;
                kind   <= addressed ? K_RHI : K_HI;
            end else begin
                case (st)
                    ST_RX: begin
                        if (ev.scl_rise && bitcnt < CNT_W'(BYTE_W)) begin
                            sh     <= {sh[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.scl_fall && bitcnt == CNT_W'(BYTE_W)) begin
                            if (hit) begin
                                st <= ST_ACK; nxt <= nxt_c; rx_data <= sh; buf_full <= 1'b1;
                            end else begin
                                st <= ST_IDLE; addressed <= 1'b0; kind <= K_HI;
                            end
                        end
                    end
                    ST_ACK: if (ev.scl_fall) begin
                        irq    <= 1'b1;
                        bitcnt <= '0;
                        case (nxt)
                            N_LO:   begin st <= ST_RX; kind <= K_LO; addressed <= 1'b0; upd_addr <= 1'b1; end
                            N_WAIT: begin st <= ST_WAIT; addressed <= 1'b1; upd_addr <= 1'b1; end
                            default: begin st <= ST_TX; clk_rel <= 1'b0; end
                        endcase
                    end
                    ST_TX: if (ev.scl_fall) begin
                        sh     <= {sh[BYTE_W-2:0], 1'b0};
                        bitcnt <= bitcnt + 1'b1;
                        if (bitcnt == CNT_W'(BYTE_W - 1)) begin
                            st <= ST_TXACK; buf_full <= 1'b0;
                        end
                    end
                    ST_TXACK: begin
                        if (ev.scl_rise) m_ack <= ~ev.sda;
                        if (ev.scl_fall) begin
                            irq <= 1'b1;
                            if (m_ack) begin
                                st <= ST_TX; bitcnt <= '0; clk_rel <= 1'b0;
                            end else begin
                                st <= ST_IDLE; addressed <= 1'b0; kind <= K_HI;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            if (addr_we) begin
                addr_q   <= addr_wdata;
                upd_addr <= 1'b0;
            end
            if (rx_re) buf_full <= 1'b0;
            if (tx_we && st == ST_TX && bitcnt == '0) begin
                sh       <= tx_wdata;
                buf_full <= 1'b1;
            end
            if (irq_clr) irq <= 1'b0;
            if (rel_set) clk_rel <= 1'b1;
        end
    end

    assign sda_oe = (st == ST_ACK) || (st == ST_TX && !sh[BYTE_W-1]);
    assign scl_oe = (upd_addr && (st == ST_RX || st == ST_WAIT)) || (st == ST_TX && !clk_rel);
    assign st_o   = st;
endmodule

// File: rtl/i2c10_slave.sv
module i2c10_slave
    import i2c10_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              addr_we,
    input  logic [BYTE_W-1:0] addr_wdata,
    input  logic              tx_we,
    input  logic [BYTE_W-1:0] tx_wdata,
    input  logic              rx_re,
    input  logic              rel_set,
    input  logic              irq_clr,
    output logic [BYTE_W-1:0] addr_q,
    output logic [BYTE_W-1:0] rx_data,
    output logic              buf_full,
    output logic              upd_addr,
    output logic              irq,
    output logic              clk_rel
);
    bus_ev_t ev;
    st_e     st;
    logic    stop_ev;

    i2c10_linesync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    i2c10_engine u_eng (
        .clk(clk), .rst(rst), .ev(ev),
        .addr_we(addr_we), .addr_wdata(addr_wdata),
        .tx_we(tx_we), .tx_wdata(tx_wdata),
        .rx_re(rx_re), .rel_set(rel_set), .irq_clr(irq_clr),
        .sda_oe(sda_oe), .scl_oe(scl_oe), .addr_q(addr_q), .rx_data(rx_data),
        .buf_full(buf_full), .upd_addr(upd_addr), .irq(irq), .clk_rel(clk_rel),
        .st_o(st)
    );

    assign stop_ev = ev.stop;
endmodule

// File: rtl/i2c10_chk.sv
module i2c10_chk
    import i2c10_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic scl_oe,
    input logic sda_oe,
    input logic addr_we,
    input logic rel_set,
    input logic irq_clr,
    input logic upd_addr,
    input logic irq,
    input logic clk_rel,
    input logic stop_ev,
    input st_e  st
);
    p_ua_hold_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(upd_addr) |-> scl_oe);

    p_ua_clear_r4: assert property (@(posedge clk) disable iff (rst)
        addr_we |=> !upd_addr);

    p_irq_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    p_rel_set_r7: assert property (@(posedge clk) disable iff (rst)
        rel_set |=> clk_rel);

    p_stop_idle_r10: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> (st == ST_IDLE));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> (!sda_oe && !scl_oe));
endmodule

bind i2c10_slave i2c10_chk u_chk (
    .clk(clk), .rst(rst), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .addr_we(addr_we), .rel_set(rel_set), .irq_clr(irq_clr),
    .upd_addr(upd_addr), .irq(irq), .clk_rel(clk_rel),
    .stop_ev(stop_ev), .st(st)
);

// File: tb/sim_i2c10_slave.sv
module sim_i2c10_slave;
    localparam int T = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_oe, sda_oe;
    logic addr_we = 0, tx_we = 0, rx_re = 0, rel_set = 0, irq_clr = 0;
    logic [7:0] addr_wdata = 0, tx_wdata = 0;
    logic [7:0] addr_q, rx_data;
    logic buf_full, upd_addr, irq, clk_rel;
    wire scl_ln = !(m_scl_low | scl_oe);
    wire sda_ln = !(m_sda_low | sda_oe);

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    i2c10_slave u0 (
        .clk(clk), .rst(rst), .scl_i(scl_ln), .sda_i(sda_ln),
        .scl_oe(scl_oe), .sda_oe(sda_oe),
        .addr_we(addr_we), .addr_wdata(addr_wdata),
        .tx_we(tx_we), .tx_wdata(tx_wdata),
        .rx_re(rx_re), .rel_set(rel_set), .irq_clr(irq_clr),
        .addr_q(addr_q), .rx_data(rx_data), .buf_full(buf_full),
        .upd_addr(upd_addr), .irq(irq), .clk_rel(clk_rel)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic h_addr(input logic [7:0] v);
        addr_wdata = v; addr_we = 1; wt(1); addr_we = 0; wt(1);
    endtask
    task automatic h_tx(input logic [7:0] v);
        tx_wdata = v; tx_we = 1; wt(1); tx_we = 0; wt(1);
    endtask
    task automatic h_rel();    rel_set = 1; wt(1); rel_set = 0; wt(1); endtask
    task automatic h_irqclr(); irq_clr = 1; wt(1); irq_clr = 0; wt(1); endtask
    task automatic h_rxre();   rx_re = 1;   wt(1); rx_re = 0;   wt(1); endtask

    task automatic scl_up();
        m_scl_low = 0;
        while (!scl_ln) wt(1);
    endtask

    task automatic m_start();
        m_sda_low = 0; wt(T); scl_up(); wt(T);
        m_sda_low = 1; wt(T); m_scl_low = 1; wt(T);
    endtask
    task automatic m_stop();
        m_sda_low = 1; wt(T); scl_up(); wt(T); m_sda_low = 0; wt(T);
    endtask
    task automatic m_wbit(input logic b);
        m_sda_low = !b; wt(T); scl_up(); wt(T); m_scl_low = 1; wt(4);
    endtask
    task automatic m_rbit(output logic b);
        m_sda_low = 0; wt(T); scl_up(); wt(T/2); b = sda_ln; wt(T/2); m_scl_low = 1; wt(4);
    endtask
    task automatic m_wbyte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_wbit(v[i]);
        m_rbit(b);
        ack = !b;
    endtask
    task automatic m_rbyte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) m_rbit(v[i]);
    endtask

    // host answers an update-address request: checks the hold, then rewrites
    task automatic serve_ua(input logic [7:0] v, input string tag);
        wt(5);
        chk({tag, " upd_addr set"}, upd_addr, 1);
        wt(40);
        chk({tag, " scl held"}, scl_ln, 0);
        h_addr(v);
        chk({tag, " upd_addr cleared"}, upd_addr, 0);
        chk({tag, " scl released"}, scl_oe, 0);
    endtask

    task automatic t_reset();
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 buf_full", buf_full, 0);
        chk("R1 upd_addr", upd_addr, 0);
        chk("R1 irq", irq, 0);
        chk("R1 clk_rel", clk_rel, 1);
    endtask

    task automatic t_read();
        logic a; logic [7:0] d;
        h_addr(8'hF4);
        m_start();
        m_wbyte(8'hF4, a);
        chk("R2 header ack", a, 1);
        wt(5);
        chk("R5 irq set", irq, 1);
        chk("R6 buf_full set", buf_full, 1);
        chk("R6 rx_data", rx_data, 8'hF4);
        wt(40);
        chk("R5 irq sticky", irq, 1);
        h_rxre();
        chk("R6 buf_full cleared by read", buf_full, 0);
        h_irqclr();
        chk("R5 irq cleared", irq, 0);
        serve_ua(8'hA5, "R4 first");
        m_wbyte(8'hA5, a);
        chk("R3 low byte ack", a, 1);
        chk("R6 rx_data low", rx_data, 8'hA5);
        serve_ua(8'hF4, "R4 second");
        h_rxre(); h_irqclr();
        m_start();
        m_wbyte(8'hF5, a);
        chk("R7 read header ack", a, 1);
        wt(5);
        chk("R7 clk_rel cleared", clk_rel, 0);
        chk("R7 no ua on read", upd_addr, 0);
        wt(40);
        chk("R7 scl held", scl_ln, 0);
        h_rxre(); h_irqclr();
        h_tx(8'h96);
        chk("R8 buf_full on tx write", buf_full, 1);
        h_rel();
        m_rbyte(d);
        chk("R8 first data", d, 8'h96);
        wt(2);
        chk("R8 buf_full cleared after shift", buf_full, 0);
        m_wbit(1'b0);
        wt(5);
        chk("R9 clk_rel cleared after ack", clk_rel, 0);
        chk("R9 scl held after ack", scl_oe, 1);
        chk("R5 irq after tx byte", irq, 1);
        h_irqclr();
        h_tx(8'h3C);
        h_rel();
        m_rbyte(d);
        chk("R8 second data", d, 8'h3C);
        m_wbit(1'b1);
        wt(5);
        chk("R9 sda released after nack", sda_oe, 0);
        chk("R9 scl released after nack", scl_oe, 0);
        m_stop();
        h_irqclr();
    endtask

    task automatic t_bad_hdr();
        logic a;
        m_start();
        m_wbyte(8'hF6, a);
        chk("R2 wrong header nack", a, 0);
        m_wbyte(8'hF4, a);
        chk("R2 ignored until start", a, 0);
        chk("R2 no ua", upd_addr, 0);
        chk("R2 no irq", irq, 0);
        m_stop();
    endtask

    task automatic t_bad_lo();
        logic a;
        m_start();
        m_wbyte(8'hF4, a);
        chk("R2 header ack", a, 1);
        serve_ua(8'hA5, "R4 lo test");
        m_wbyte(8'h5A, a);
        chk("R3 wrong low nack", a, 0);
        wt(5);
        chk("R3 no ua after nack", upd_addr, 0);
        m_stop();
        h_addr(8'hF4);
        h_irqclr(); h_rxre();
    endtask

    task automatic t_read_unaddr();
        logic a;
        m_start();
        m_wbyte(8'hF5, a);
        chk("R11 read header nack", a, 0);
        m_stop();
    endtask

    task automatic t_stop_clears();
        logic a;
        m_start();
        m_wbyte(8'hF4, a);
        serve_ua(8'hA5, "R4 stop test");
        m_wbyte(8'hA5, a);
        chk("R3 low ack", a, 1);
        serve_ua(8'hF4, "R4 stop test2");
        m_stop();
        wt(5);
        chk("R10 sda released", sda_oe, 0);
        chk("R10 scl released", scl_oe, 0);
        m_start();
        m_wbyte(8'hF5, a);
        chk("R10 read after stop nack", a, 0);
        m_stop();
        h_irqclr(); h_rxre();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            finish_run();
        end
    end

    initial begin
        wt(4);
        rst = 0;
        wt(4);
        t_reset();
        t_read();
        t_bad_hdr();
        t_bad_lo();
        t_read_unaddr();
        t_stop_clears();
        wt(10);
        finish_run();
    end
endmodule